// File: doc/BRIEF.md
# Three-Wire Control Register Slave

This block gives a host access to a bank of ten 8-bit control registers over a three-wire serial port. The port has an active-low select, a serial clock and one shared data line. The shared line is split at the block's edge into an input, an output and an output enable. The serial signals come from outside the block's clock domain. The block samples them with a system clock through a two-stage synchronizer and then finds the serial clock edges from the synchronized levels. The serial clock must therefore run well below the system clock. Each of its half periods must last several system cycles.

A frame is sixteen serial clock rising edges long. It carries a three-bit op-code, then a five-bit address, then eight data bits. The address and data fields are sent least significant bit first.

- A write frame updates its register only when the select returns high, and only if exactly sixteen rising edges occurred.
- A read frame turns the line into an output once the address is complete, and shifts out a copy of the addressed register.
- Malformed frames change nothing.

All register contents are presented in parallel to the rest of the chip.

Top module: `ctl3w_slave`

## Requirements
- R1: Within a frame the host sends, in order, op0, op1, op2, A0..A4 and D0..D7. The field value is the sum of bit_i·2^i. Register k sits on reg_flat[8k+7:8k].
- R2: A frame with op0=op1=op2=1, exactly 16 rising CCLK edges and an address below 10 loads D into the addressed register. The load happens only after cs_n rises.
- R3: A frame with op0=op1=1 and op2=0 and an address below 10 is a read. dio_oe rises after the 8th rising edge. D0..D7 of the register then appear on dio_out, LSB first, one bit per falling edge. The first bit follows the falling edge after the 8th rising edge.
- R4: A read frame leaves every register unchanged.
- R5: A frame with op0=0 or op1=0 writes nothing and never asserts dio_oe.
- R6: A write frame with a rising-edge count other than 16 (15 or 17) leaves every register unchanged.
- R7: A frame with an address of 10 or more writes nothing and never asserts dio_oe.
- R8: dio_oe is low while cs_n is high, and it falls after cs_n rises at the end of a read.
- R9: After reset all registers read 00h and dio_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select |
| cclk | input | 1 | Serial clock from the host |
| dio_in | input | 1 | Shared data line, input side |
| dio_out | output | 1 | Shared data line, output value |
| dio_oe | output | 1 | Drive enable for the shared data line |
| reg_flat | output | 80 | All ten registers, register k on bits 8k+7:8k |

## Verification
Several rules are checked by assertions on every cycle. The drive enable is only ever set during a read op-code and never while select is high. A register commit only follows a select rising edge and only targets an in-range address. The registers hold whenever no commit is issued. Other behaviour can only be shown by the bench's frames: the bit order of the fields, the exact edge-count rule, the serial order of the read bits, and the rejection of bad op-codes and addresses. The bench compares the register outputs and the shifted-out bits with a model of the register bank.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
    // op-code register holds op0 in bit 0, op1 in bit 1, op2 in bit 2
    localparam logic [2:0] OP_WRITE = 3'b111;
    localparam logic [2:0] OP_READ  = 3'b011;
    localparam int         OP_BITS  = 3;
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
    parameter int           N    = 3,
    parameter int           NE   = 2,
    parameter logic [N-1:0] INIT = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  raw,
    output logic [N-1:0]  lvl,
    output logic [NE-1:0] prev
);
    logic [N-1:0]  meta_q, meta_d;
    logic [N-1:0]  sync_q, sync_d;
    logic [NE-1:0] prev_q, prev_d;

    always_comb begin
        meta_d = raw;
        sync_d = meta_q;
        prev_d = sync_q[NE-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= INIT;
            sync_q <= INIT;
            prev_q <= INIT[NE-1:0];
        end else begin
            meta_q <= meta_d;
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign lvl  = sync_q;
    assign prev = prev_q;
endmodule

// File: rtl/ctl3w_regbank.sv
module ctl3w_regbank #(
    parameter int NREG = 10,
    parameter int AW   = 5,
    parameter int DW   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [AW-1:0]      rd_addr,
    output logic [DW-1:0]      rd_data,
    output logic [NREG*DW-1:0] reg_flat
);
    logic [DW-1:0] mem_q [NREG];
    logic [DW-1:0] mem_d [NREG];

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            mem_d[i] = mem_q[i];
            if (wr_en && wr_addr == AW'(i)) mem_d[i] = wr_data;
            if (rd_addr == AW'(i)) rd_data = mem_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) mem_q[i] <= mem_d[i];
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign reg_flat[g*DW +: DW] = mem_q[g];
    end

    // R7: a commit never targets an address outside the bank
    a_r7_commit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(wr_addr) < NREG));

    // R4: without a commit the bank holds its contents
    a_r4_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(reg_flat));
endmodule

// File: rtl/ctl3w_frame.sv
module ctl3w_frame
    import ctl3w_pkg::*;
#(
    parameter int NREG = 10,
    parameter int AW   = 5,
    parameter int DW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_lvl,
    input  logic          cs_prev,
    input  logic          ck_lvl,
    input  logic          ck_prev,
    input  logic          din,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          dout,
    output logic          oe
);
    localparam int HDR   = OP_BITS + AW;
    localparam int FRAME = HDR + DW;
    localparam int CW    = $clog2(FRAME + 2);

    typedef struct packed {
        logic [CW-1:0]      cnt;
        logic [OP_BITS-1:0] op;
        logic [AW-1:0]      addr;
        logic [DW-1:0]      data;
        logic [DW-1:0]      shf;
        logic               dout;
        logic               oe;
        logic               we;
    } st_t;

    st_t st_q, st_d;
    logic cs_rise, cs_fall, ck_rise, ck_fall;

    function automatic logic in_range(input logic [AW-1:0] a);
        return 32'(a) < NREG;
    endfunction

    always_comb begin
        cs_rise = cs_lvl & ~cs_prev;
        cs_fall = ~cs_lvl & cs_prev;
        ck_rise = ck_lvl & ~ck_prev;
        ck_fall = ~ck_lvl & ck_prev;
        st_d    = st_q;
        st_d.we = 1'b0;
        if (cs_fall) begin
            st_d.cnt  = '0;
            st_d.oe   = 1'b0;
            st_d.dout = 1'b0;
        end else if (cs_rise) begin
            st_d.oe = 1'b0;
            if (st_q.cnt == CW'(FRAME) && st_q.op == OP_WRITE && in_range(st_q.addr))
                st_d.we = 1'b1;
        end else if (!cs_lvl) begin
            if (ck_rise) begin
                if (st_q.cnt < CW'(OP_BITS))
                    st_d.op = {din, st_q.op[OP_BITS-1:1]};
                else if (st_q.cnt < CW'(HDR))
                    st_d.addr = {din, st_q.addr[AW-1:1]};
                else if (st_q.cnt < CW'(FRAME))
                    st_d.data = {din, st_q.data[DW-1:1]};
                if (st_q.cnt != CW'(FRAME + 1))
                    st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == CW'(HDR - 1) && st_d.op == OP_READ && in_range(st_d.addr)) begin
                    st_d.oe  = 1'b1;
                    st_d.shf = rd_data;
                end
            end else if (ck_fall && st_q.oe && st_q.cnt >= CW'(HDR) && st_q.cnt < CW'(FRAME)) begin
                st_d.dout = st_q.shf[0];
                st_d.shf  = st_q.shf >> 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_addr = st_d.addr;
    assign wr_en   = st_q.we;
    assign wr_addr = st_q.addr;
    assign wr_data = st_q.data;
    assign dout    = st_q.dout;
    assign oe      = st_q.oe;

    // R8: no drive while the select is settled high
    a_r8_no_drive_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_lvl && cs_prev) |-> !st_q.oe);

    // R2: a commit is issued only right after a select rising edge
    a_r2_commit_after_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.we |-> $past(cs_rise));

    // R3: the driver is on only for a read op-code
    a_r3_drive_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.oe |-> (st_q.op == OP_READ));
endmodule

// File: rtl/ctl3w_slave.sv
module ctl3w_slave #(
    parameter int NREG = 10,
    parameter int AW   = 5,
    parameter int DW   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               cclk,
    input  logic               dio_in,
    output logic               dio_out,
    output logic               dio_oe,
    output logic [NREG*DW-1:0] reg_flat
);
    logic [2:0]    lvl;
    logic [1:0]    prev;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [DW-1:0] rd_data, wr_data;
    logic          wr_en;

    ctl3w_sync #(.N(3), .NE(2), .INIT(3'b001)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({dio_in, cclk, cs_n}),
        .lvl  (lvl),
        .prev (prev)
    );

    ctl3w_frame #(.NREG(NREG), .AW(AW), .DW(DW)) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_lvl (lvl[0]),
        .cs_prev(prev[0]),
        .ck_lvl (lvl[1]),
        .ck_prev(prev[1]),
        .din    (lvl[2]),
        .rd_data(rd_data),
        .rd_addr(rd_addr),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .dout   (dio_out),
        .oe     (dio_oe)
    );

    ctl3w_regbank #(.NREG(NREG), .AW(AW), .DW(DW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .reg_flat(reg_flat)
    );
endmodule

// File: tb/ctl3w_slave_test.sv
`timescale 1ns/1ps
module ctl3w_slave_test;
    localparam int NREG = 10;
    localparam int H    = 6;
    localparam int NV   = 15;

    // {op2,op1,op0}, addr, data, rising-edge count
    localparam logic [20:0] VEC [NV] = '{
        {3'b111, 5'd0,  8'hA5, 5'd16},
        {3'b111, 5'd9,  8'h3C, 5'd16},
        {3'b111, 5'd3,  8'h81, 5'd16},
        {3'b011, 5'd0,  8'hFF, 5'd16},
        {3'b011, 5'd9,  8'h00, 5'd16},
        {3'b011, 5'd3,  8'h5A, 5'd16},
        {3'b111, 5'd10, 8'hFF, 5'd16},
        {3'b011, 5'd10, 8'h00, 5'd16},
        {3'b111, 5'd31, 8'h12, 5'd16},
        {3'b111, 5'd4,  8'h77, 5'd15},
        {3'b111, 5'd4,  8'h66, 5'd17},
        {3'b110, 5'd5,  8'h99, 5'd16},
        {3'b101, 5'd6,  8'h42, 5'd16},
        {3'b111, 5'd7,  8'hC3, 5'd16},
        {3'b011, 5'd7,  8'h00, 5'd16}
    };

    logic clk = 0, rst_n = 0, cs_n = 1, cclk = 0, dio_in = 0;
    logic dio_out, dio_oe;
    logic [NREG*8-1:0] reg_flat;
    logic [7:0] model [NREG];
    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ctl3w_slave uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cclk(cclk),
                     .dio_in(dio_in), .dio_out(dio_out), .dio_oe(dio_oe),
                     .reg_flat(reg_flat));

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input string what,
                         input logic [79:0] got, input logic [79:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [79:0] model_flat();
        logic [79:0] f;
        for (int i = 0; i < NREG; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    task automatic frame(input logic [2:0] op, input logic [4:0] addr,
                         input logic [7:0] data, input int edges,
                         output logic [7:0] rd, output logic oe_all, output logic oe_any);
        rd = '0; oe_all = 1; oe_any = 0;
        cs_n = 0;
        wait_n(H);
        for (int i = 0; i < edges; i++) begin
            if (i < 3)       dio_in = op[i];
            else if (i < 8)  dio_in = addr[i-3];
            else if (i < 16) dio_in = data[i-8];
            else             dio_in = 0;
            wait_n(H);
            oe_any = oe_any | dio_oe;
            if (i >= 8 && i < 16) begin
                rd[i-8] = dio_out;
                oe_all  = oe_all & dio_oe;
            end
            cclk = 1;
            wait_n(H);
            oe_any = oe_any | dio_oe;
            cclk = 0;
        end
        wait_n(H);
        oe_any = oe_any | dio_oe;
        cs_n = 1;
        wait_n(12);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic oe_all, oe_any;
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        wait_n(5);
        check("R9", "regs after reset", 80'(reg_flat), 80'h0);
        check("R9", "oe after reset", 80'(dio_oe), 80'h0);
        rst_n = 1;
        wait_n(5);
        check("R8", "oe idle", 80'(dio_oe), 80'h0);

        for (int v = 0; v < NV; v++) begin
            logic [2:0] op;
            logic [4:0] ad;
            logic [7:0] dt;
            int ne;
            logic isrd;
            string tag;
            op = VEC[v][20:18]; ad = VEC[v][17:13];
            dt = VEC[v][12:5];  ne = int'(VEC[v][4:0]);
            isrd = (op == 3'b011) && (ad < NREG);
            if (op[1:0] != 2'b11)           tag = "R5";
            else if (ad >= NREG)            tag = "R7";
            else if (op == 3'b011)          tag = "R3 R4";
            else if (ne != 16)              tag = "R6";
            else                            tag = "R1 R2";
            frame(op, ad, dt, ne, rd, oe_all, oe_any);
            if (op == 3'b111 && ne == 16 && ad < NREG) model[ad] = dt;
            check(tag, "register bank", reg_flat, model_flat());
            if (isrd) begin
                check("R3", "read data", 80'(rd), 80'(model[ad]));
                check("R3", "oe during data", 80'(oe_all), 80'h1);
            end else begin
                check(tag, "oe seen", 80'(oe_any), 80'h0);
            end
            check("R8", "oe after cs rise", 80'(dio_oe), 80'h0);
        end

        // read before the address is complete: no drive in the header phase
        cs_n = 0;
        wait_n(H);
        for (int i = 0; i < 8; i++) begin
            dio_in = (i < 2) ? 1'b1 : ((i == 3) ? 1'b1 : 1'b0);
            wait_n(H);
            if (i == 7) check("R3", "oe before 8th rise", 80'(dio_oe), 80'h0);
            cclk = 1;
            wait_n(H);
            cclk = 0;
        end
        wait_n(H);
        check("R3", "oe after 8th rise", 80'(dio_oe), 80'h1);
        cs_n = 1;
        wait_n(12);
        check("R8", "oe after short read", 80'(dio_oe), 80'h0);
        check("R4", "bank after short read", reg_flat, model_flat());

        // reset clears written contents
        rst_n = 0;
        wait_n(3);
        check("R9", "regs after second reset", 80'(reg_flat), 80'h0);
        rst_n = 1;
        wait_n(3);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule